// File: doc/BRIEF.md
# Dual PS/2 Port Register Controller

This block places two identical PS/2 port register sets on a simple byte-wide bus: port 0 serves the keyboard and port 1 serves the mouse. Each set has four read registers and three write registers. On the read side are an identity value, a receive-data register, a control register and a status register. On the write side are a reset strobe, a transmit-data register and the control register. Each port talks to a byte-stream device through four signals: a transmit strobe with its byte, a receive pop, a receive-not-empty flag with the head byte, and a device interrupt level. The wire-level serializer and the device models sit outside the block.

A loopback mode in each port's control register turns a transmit write into a local receive byte that raises that port's interrupt. Reading the byte back clears the interrupt. In diagnostic mode the status register's line-shadow bits follow the control register's direction bits. The interrupt output, and status bit 4 of both ports, report the OR of the two port interrupts.

Top module: `ps2_dual_regctl`

## Requirements
- R1: Address bit 8 selects the port (0 keyboard, 1 mouse) and bits [3:2] select the register; all other address bits are ignored. Read offsets are 0 identity, 4 receive data, 8 control and 12 status. The identity reads 0 on the keyboard port and 1 on the mouse port.
- R2: Read data appears on `bus_rdata` in the cycle after the read request. After any cycle without a read, `bus_rdata` is 0.
- R3: Offset 8 holds an 8-bit control value that reads back exactly as written. Its bits are: bit 0 enable, bit 1 loopback, bit 5 diagnostic, bit 6 data-line direction, bit 7 clock-line direction.
- R4: With loopback set, a write to offset 4 produces no device transmit strobe. The write latches the byte and sets both the port's loopback-not-empty flag and its interrupt.
- R5: With loopback clear, a write to offset 4 raises that port's `dev_tx_stb` for one cycle, with the written byte on `dev_tx_byte`.
- R6: With loopback set, a read of offset 4 returns the latched byte and clears the flag and the interrupt, with no pop. With loopback clear, the read pulses `dev_rx_pop` in the request cycle and returns `dev_rx_byte`.
- R7: Status bit 6 (data shadow) and bit 7 (clock shadow) read 1. With diagnostic set, each one reads 0 when its direction bit is 0.
- R8: Status bit 0 is the loopback-not-empty flag when loopback is set, and `dev_rx_ne` otherwise. Status bits 1, 2, 3 and 5 read 0.
- R9: Status bit 4 reads 1 on both ports whenever either port's interrupt is pending.
- R10: `irq` is the OR of the two port interrupts. Outside loopback, a port interrupt takes the value `dev_irq` had one cycle earlier.
- R11: Writes to offset 0 and offset 12 change nothing, and status reads have no side effect on the device queue.
- R12: A synchronous active-high reset clears control, the loopback bytes, the flags, the interrupts and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_vld | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 9 | Byte address; bit 8 port, bits [3:2] register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the request |
| dev_tx_stb | output | 2 | Per-port transmit-byte strobe |
| dev_tx_byte | output | 2x8 | Per-port transmit byte |
| dev_rx_pop | output | 2 | Per-port receive pop |
| dev_rx_byte | input | 2x8 | Per-port head byte of the receive queue |
| dev_rx_ne | input | 2 | Per-port receive-queue-not-empty |
| dev_irq | input | 2 | Per-port device interrupt level |
| irq | output | 1 | Combined interrupt |

## Verification
Two results are due one edge after their stimulus: read data, and every state change caused by a write (control, loopback flag, port interrupt). A device interrupt level likewise reaches `irq` one edge later. Transmit strobes and receive pops are combinational in the request cycle, so the bench stub consumes them at that same edge. The bench drives each request at a falling edge and samples at the next falling edge, halfway after the edge that made the result. A status read made right after a write therefore already sees the write's effect.

// File: rtl/ps2rc_pkg.sv
package ps2rc_pkg;

    localparam int DW = 8;

    // register slot selected by address bits [3:2]; slot 0 is identity on read, reset on write
    typedef enum logic [1:0] {
        OFS_ID   = 2'd0,
        OFS_DATA = 2'd1,
        OFS_CTRL = 2'd2,
        OFS_STAT = 2'd3
    } ofs_e;

    // control bit positions
    localparam int CB_EN   = 0;
    localparam int CB_LOOP = 1;
    localparam int CB_DIAG = 5;
    localparam int CB_DDIR = 6;
    localparam int CB_CDIR = 7;

    // status bit positions
    localparam int SB_RXNE = 0;
    localparam int SB_TXNE = 1;
    localparam int SB_TERR = 2;
    localparam int SB_PERR = 3;
    localparam int SB_IRQ  = 4;
    localparam int SB_DSH  = 6;
    localparam int SB_CSH  = 7;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] lb_byte;
        logic          lb_ne;
        logic          irq;
    } port_st_t;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } top_st_t;

endpackage

// File: rtl/ps2rc_decode.sv
module ps2rc_decode
    import ps2rc_pkg::*;
#(
    parameter int NPORT   = 2,
    parameter int WIN_LSB = 8,
    parameter int PW      = 1,
    parameter int AW      = 9
) (
    input  logic             bus_vld,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    output logic [NPORT-1:0] acc_rd,
    output logic [NPORT-1:0] acc_wr,
    output ofs_e             ofs
);

    logic unused_addr_bits;
    assign unused_addr_bits = ^{bus_addr[WIN_LSB-1:4], bus_addr[1:0]};

    assign ofs = ofs_e'(bus_addr[3:2]);

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_hit
        logic hit;
        assign hit        = (bus_addr[WIN_LSB +: PW] == PW'(gi));
        assign acc_rd[gi] = bus_vld && !bus_wr && hit;
        assign acc_wr[gi] = bus_vld &&  bus_wr && hit;
    end

endmodule

// File: rtl/ps2rc_port.sv
module ps2rc_port
    import ps2rc_pkg::*;
#(
    parameter int PORT_ID = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_rd,
    input  logic          acc_wr,
    input  ofs_e          ofs,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_ne,
    input  logic          dev_irq,
    input  logic          irq_any,
    output logic [DW-1:0] rd_val,
    output logic          tx_stb,
    output logic [DW-1:0] tx_byte,
    output logic          rx_pop,
    output logic          irq,
    output logic [DW-1:0] ctrl
);

    port_st_t st_q, st_d;
    logic     loop_on;
    logic     irq_set, irq_clr;
    logic [DW-1:0] status;

    assign loop_on = st_q.ctrl[CB_LOOP];

    always_comb begin
        status          = '0;
        status[SB_DSH]  = !(st_q.ctrl[CB_DIAG] && !st_q.ctrl[CB_DDIR]);
        status[SB_CSH]  = !(st_q.ctrl[CB_DIAG] && !st_q.ctrl[CB_CDIR]);
        status[SB_RXNE] = loop_on ? st_q.lb_ne : rx_ne;
        status[SB_IRQ]  = irq_any;
        status[SB_TXNE] = 1'b0;
        status[SB_TERR] = 1'b0;
        status[SB_PERR] = 1'b0;
    end

    always_comb begin
        st_d    = st_q;
        tx_stb  = 1'b0;
        tx_byte = wdata;
        rx_pop  = 1'b0;
        rd_val  = '0;
        irq_set = 1'b0;
        irq_clr = 1'b0;

        if (acc_rd) begin
            unique case (ofs)
                OFS_ID:   rd_val = DW'(PORT_ID);
                OFS_DATA: begin
                    if (loop_on) begin
                        rd_val      = st_q.lb_byte;
                        st_d.lb_ne  = 1'b0;
                        irq_clr     = 1'b1;
                    end else begin
                        rd_val = rx_byte;
                        rx_pop = 1'b1;
                    end
                end
                OFS_CTRL: rd_val = st_q.ctrl;
                OFS_STAT: rd_val = status;
                default:  rd_val = '0;
            endcase
        end

        if (acc_wr) begin
            unique case (ofs)
                OFS_DATA: begin
                    if (loop_on) begin
                        st_d.lb_byte = wdata;
                        st_d.lb_ne   = 1'b1;
                        irq_set      = 1'b1;
                    end else begin
                        tx_stb = 1'b1;
                    end
                end
                OFS_CTRL: st_d.ctrl = wdata;
                default:  ;
            endcase
        end

        if (loop_on) begin
            if (irq_set)      st_d.irq = 1'b1;
            else if (irq_clr) st_d.irq = 1'b0;
        end else begin
            st_d.irq = dev_irq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign irq  = st_q.irq;
    assign ctrl = st_q.ctrl;

endmodule

// File: rtl/ps2_dual_regctl.sv
module ps2_dual_regctl
    import ps2rc_pkg::*;
#(
    parameter  int NPORT   = 2,
    parameter  int WIN_LSB = 8,
    localparam int PW      = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int AW      = WIN_LSB + PW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_vld,
    input  logic                      bus_wr,
    input  logic [AW-1:0]             bus_addr,
    input  logic [DW-1:0]             bus_wdata,
    output logic [DW-1:0]             bus_rdata,
    output logic [NPORT-1:0]          dev_tx_stb,
    output logic [NPORT-1:0][DW-1:0]  dev_tx_byte,
    output logic [NPORT-1:0]          dev_rx_pop,
    input  logic [NPORT-1:0][DW-1:0]  dev_rx_byte,
    input  logic [NPORT-1:0]          dev_rx_ne,
    input  logic [NPORT-1:0]          dev_irq,
    output logic                      irq
);

    logic [NPORT-1:0]         acc_rd, acc_wr;
    ofs_e                     ofs;
    logic [NPORT-1:0][DW-1:0] rd_val;
    logic [NPORT-1:0][DW-1:0] port_ctrl;
    logic [NPORT-1:0]         port_irq;
    logic                     irq_any;
    top_st_t                  top_q, top_d;

    ps2rc_decode #(
        .NPORT(NPORT), .WIN_LSB(WIN_LSB), .PW(PW), .AW(AW)
    ) u_decode (
        .bus_vld (bus_vld),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .acc_rd  (acc_rd),
        .acc_wr  (acc_wr),
        .ofs     (ofs)
    );

    assign irq_any = |port_irq;

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
        ps2rc_port #(.PORT_ID(gp)) u_port (
            .clk    (clk),
            .rst    (rst),
            .acc_rd (acc_rd[gp]),
            .acc_wr (acc_wr[gp]),
            .ofs    (ofs),
            .wdata  (bus_wdata),
            .rx_byte(dev_rx_byte[gp]),
            .rx_ne  (dev_rx_ne[gp]),
            .dev_irq(dev_irq[gp]),
            .irq_any(irq_any),
            .rd_val (rd_val[gp]),
            .tx_stb (dev_tx_stb[gp]),
            .tx_byte(dev_tx_byte[gp]),
            .rx_pop (dev_rx_pop[gp]),
            .irq    (port_irq[gp]),
            .ctrl   (port_ctrl[gp])
        );
    end

    always_comb begin
        top_d.rdata = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (acc_rd[i]) top_d.rdata = top_d.rdata | rd_val[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) top_q <= '0;
        else     top_q <= top_d;
    end

    assign bus_rdata = top_q.rdata;
    assign irq       = irq_any;

endmodule

// File: rtl/ps2rc_checker.sv
module ps2rc_checker
    import ps2rc_pkg::*;
#(
    parameter int NPORT   = 2,
    parameter int WIN_LSB = 8,
    parameter int PW      = 1,
    parameter int AW      = 9
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_vld,
    input logic                      bus_wr,
    input logic [AW-1:0]             bus_addr,
    input logic [DW-1:0]             bus_rdata,
    input logic [NPORT-1:0]          dev_tx_stb,
    input logic [NPORT-1:0]          dev_rx_pop,
    input logic [NPORT-1:0]          dev_irq,
    input logic [NPORT-1:0]          port_irq,
    input logic [NPORT-1:0][DW-1:0]  port_ctrl
);

    logic rd_req;
    assign rd_req = bus_vld && !bus_wr;

    // R2: no read request leaves zero on the read bus next cycle
    p_idle_rdata_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> (bus_rdata == '0));

    // R1: identity slot returns the port index one cycle later
    p_id_read_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_req && bus_addr[3:2] == 2'd0)
        |=> (bus_rdata == DW'($past(bus_addr[WIN_LSB +: PW]))));

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_chk
        logic hit;
        assign hit = (bus_addr[WIN_LSB +: PW] == PW'(gi));

        // R6: a pop only on a non-loopback data read of this port
        p_pop_on_data_read_r6: assert property (@(posedge clk) disable iff (rst)
            dev_rx_pop[gi] |-> (rd_req && hit && bus_addr[3:2] == 2'd1
                                && !port_ctrl[gi][CB_LOOP]));

        // R5: a transmit strobe only on a non-loopback data write of this port
        p_tx_on_data_write_r5: assert property (@(posedge clk) disable iff (rst)
            dev_tx_stb[gi] |-> (bus_vld && bus_wr && hit && bus_addr[3:2] == 2'd1
                                && !port_ctrl[gi][CB_LOOP]));

        // R4: loopback data write raises the port interrupt
        p_loop_write_irq_r4: assert property (@(posedge clk) disable iff (rst)
            (bus_vld && bus_wr && hit && bus_addr[3:2] == 2'd1 && port_ctrl[gi][CB_LOOP])
            |=> port_irq[gi]);

        // R10: outside loopback the port interrupt tracks the device level
        p_irq_follows_dev_r10: assert property (@(posedge clk) disable iff (rst)
            !port_ctrl[gi][CB_LOOP] |=> (port_irq[gi] == $past(dev_irq[gi])));
    end

endmodule

bind ps2_dual_regctl ps2rc_checker #(
    .NPORT(NPORT), .WIN_LSB(WIN_LSB), .PW(PW), .AW(AW)
) u_ps2rc_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_vld   (bus_vld),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .dev_tx_stb(dev_tx_stb),
    .dev_rx_pop(dev_rx_pop),
    .dev_irq   (dev_irq),
    .port_irq  (port_irq),
    .port_ctrl (port_ctrl)
);

// File: tb/ps2_dual_regctl_bench.sv
`timescale 1ns/1ps
module ps2_dual_regctl_bench;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_vld = 1'b0;
    logic             bus_wr = 1'b0;
    logic [8:0]       bus_addr = '0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic [1:0]       dev_tx_stb;
    logic [1:0][7:0]  dev_tx_byte;
    logic [1:0]       dev_rx_pop;
    logic [1:0][7:0]  dev_rx_byte;
    logic [1:0]       dev_rx_ne;
    logic [1:0]       dev_irq = '0;
    logic             irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ps2_dual_regctl u_ps2_dual_regctl (
        .clk(clk), .rst(rst), .bus_vld(bus_vld), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_tx_stb(dev_tx_stb), .dev_tx_byte(dev_tx_byte),
        .dev_rx_pop(dev_rx_pop), .dev_rx_byte(dev_rx_byte),
        .dev_rx_ne(dev_rx_ne), .dev_irq(dev_irq), .irq(irq)
    );

    // device stubs: byte FIFOs and transmit capture
    logic [7:0] fq [2][16];
    int hd [2] = '{0, 0};
    int tl [2] = '{0, 0};
    int tx_cnt [2] = '{0, 0};
    logic [7:0] tx_last [2] = '{8'h00, 8'h00};

    always_comb begin
        for (int p = 0; p < 2; p++) begin
            dev_rx_byte[p] = fq[p][hd[p] % 16];
            dev_rx_ne[p]   = (tl[p] != hd[p]);
        end
    end

    always @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (dev_rx_pop[p]) hd[p] <= hd[p] + 1;
            if (dev_tx_stb[p]) begin
                tx_cnt[p]  <= tx_cnt[p] + 1;
                tx_last[p] <= dev_tx_byte[p];
            end
        end
    end

    task automatic push(input int p, input logic [7:0] b);
        fq[p][tl[p] % 16] = b;
        tl[p] = tl[p] + 1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one bus access starting at a falling edge; result sampled at the next falling edge
    task automatic bus(input logic w, input logic [8:0] a, input logic [7:0] d,
                       output logic [7:0] r);
        bus_vld   = 1'b1;
        bus_wr    = w;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_vld = 1'b0;
        bus_wr  = 1'b0;
        r = bus_rdata;
    endtask

    typedef struct packed {
        logic       wr;
        logic [8:0] addr;
        logic [7:0] data;
        logic       chk;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 9'h000, 8'h00, 1'b1, 8'h00, 4'd1},  // R1 keyboard identity
        '{1'b0, 9'h100, 8'h00, 1'b1, 8'h01, 4'd1},  // R1 mouse identity
        '{1'b0, 9'h0F0, 8'h00, 1'b1, 8'h00, 4'd1},  // R1 high bits ignored
        '{1'b0, 9'h1F0, 8'h00, 1'b1, 8'h01, 4'd1},  // R1 high bits ignored, mouse
        '{1'b1, 9'h008, 8'hE1, 1'b0, 8'h00, 4'd3},
        '{1'b0, 9'h008, 8'h00, 1'b1, 8'hE1, 4'd3},  // R3 control readback
        '{1'b0, 9'h00C, 8'h00, 1'b1, 8'hC0, 4'd7},  // R7 diag, both dirs 1
        '{1'b1, 9'h008, 8'h20, 1'b0, 8'h00, 4'd7},
        '{1'b0, 9'h00C, 8'h00, 1'b1, 8'h00, 4'd7},  // R7 diag, both dirs 0
        '{1'b1, 9'h008, 8'h60, 1'b0, 8'h00, 4'd7},
        '{1'b0, 9'h00C, 8'h00, 1'b1, 8'h40, 4'd7},  // R7 data dir only
        '{1'b1, 9'h008, 8'hA0, 1'b0, 8'h00, 4'd7},
        '{1'b0, 9'h00C, 8'h00, 1'b1, 8'h80, 4'd7},  // R7 clock dir only
        '{1'b1, 9'h008, 8'h00, 1'b0, 8'h00, 4'd8},
        '{1'b0, 9'h00C, 8'h00, 1'b1, 8'hC0, 4'd8},  // R8 idle status
        '{1'b1, 9'h108, 8'h02, 1'b0, 8'h00, 4'd4},
        '{1'b1, 9'h104, 8'h5A, 1'b0, 8'h00, 4'd4},
        '{1'b0, 9'h10C, 8'h00, 1'b1, 8'hD1, 4'd4},  // R4 flag and interrupt set
        '{1'b0, 9'h00C, 8'h00, 1'b1, 8'hD0, 4'd9},  // R9 other port sees interrupt
        '{1'b0, 9'h104, 8'h00, 1'b1, 8'h5A, 4'd6}   // R6 loopback byte returned
    };

    logic [7:0] r;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state at the ports
        check("R12 irq after reset", irq, 0);
        check("R12 rdata after reset", bus_rdata, 0);
        check("R12 no strobes after reset", {dev_tx_stb, dev_rx_pop}, 0);

        for (int i = 0; i < NV; i++) begin
            bus(VEC[i].wr, VEC[i].addr, VEC[i].data, r);
            if (VEC[i].chk) check($sformatf("R%0d vector %0d", VEC[i].req, i), r, VEC[i].exp);
        end
        check("R4 loopback write not transmitted", tx_cnt[1], 0);
        check("R6 loopback read does not pop", hd[1], 0);
        bus(1'b0, 9'h10C, 8'h00, r);
        check("R6 loopback read clears flag and interrupt", r, 8'hC0);
        check("R6 irq low after loopback read", irq, 0);

        // R11 reset-offset and status-offset writes do nothing
        bus(1'b1, 9'h100, 8'hFF, r);
        bus(1'b1, 9'h10C, 8'h55, r);
        bus(1'b0, 9'h108, 8'h00, r);
        check("R11 control kept after ignored writes", r, 8'h02);
        bus(1'b1, 9'h108, 8'h00, r);

        // R2 idle cycle returns zero
        bus(1'b0, 9'h100, 8'h00, r);
        @(posedge clk); @(negedge clk);
        check("R2 rdata zero after idle cycle", bus_rdata, 0);

        // R5 transmit outside loopback
        bus(1'b1, 9'h004, 8'hED, r);
        check("R5 keyboard transmit count", tx_cnt[0], 1);
        check("R5 keyboard transmit byte", tx_last[0], 8'hED);
        bus(1'b1, 9'h104, 8'hF4, r);
        check("R5 mouse transmit byte", tx_last[1], 8'hF4);
        check("R5 keyboard count unchanged", tx_cnt[0], 1);

        // R6 and R8 receive from device queue
        push(0, 8'hFA);
        push(0, 8'hAA);
        bus(1'b0, 9'h00C, 8'h00, r);
        check("R8 status shows queue not empty", r, 8'hC1);
        bus(1'b0, 9'h00C, 8'h00, r);
        check("R11 status reads pop nothing", tl[0] - hd[0], 2);
        bus(1'b0, 9'h004, 8'h00, r);
        check("R6 first popped byte", r, 8'hFA);
        bus(1'b0, 9'h004, 8'h00, r);
        check("R6 second popped byte", r, 8'hAA);
        bus(1'b0, 9'h00C, 8'h00, r);
        check("R8 status after draining", r, 8'hC0);

        // R10 device interrupt path with one cycle lag
        dev_irq = 2'b10;
        check("R10 irq not yet", irq, 0);
        @(posedge clk); @(negedge clk);
        check("R10 irq follows mouse device", irq, 1);
        bus(1'b0, 9'h00C, 8'h00, r);
        check("R9 keyboard status sees mouse interrupt", r, 8'hD0);
        dev_irq = 2'b00;
        @(posedge clk); @(negedge clk);
        check("R10 irq drops with device", irq, 0);

        // R12 mid-run reset clears loopback state and control
        bus(1'b1, 9'h108, 8'h02, r);
        bus(1'b1, 9'h104, 8'h33, r);
        check("R4 irq after loopback write", irq, 1);
        bus(1'b0, 9'h108, 8'h00, r);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check("R12 irq cleared by reset", irq, 0);
        check("R12 rdata cleared by reset", bus_rdata, 0);
        bus(1'b0, 9'h108, 8'h00, r);
        check("R12 control cleared by reset", r, 0);
        bus(1'b0, 9'h10C, 8'h00, r);
        check("R12 flag cleared by reset", r, 8'hC0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule